// File: doc/BRIEF.md
# Cache-Line Write Burst Generator

This block moves a small buffer from fabric logic into a processor's coherent memory over an AXI write port. It takes a command (a start byte address and a byte count) and a stream of bus-width data words. It then emits write bursts, each of which stays inside one 32-byte cache line. A line-aligned stretch of the buffer becomes one full-line burst. The unaligned head and tail become shorter bursts. Every write address carries a cacheable attribute encoding, whatever the upstream logic intended.

The bus width is a parameter (32, 64 or 128 bits). With ECC protection enabled, the byte range is widened outward to whole 8-byte groups, so every group that is touched is written completely. The data stream must supply exactly one word for every write beat, in address order. The block keeps one burst in flight at a time. The command port stays busy until the response to the last burst has returned. Any non-OKAY response sets a sticky error flag.

Top module: `line_burst_writer`

## Requirements
- R1: Every write address carries aw_cache = 4'b1011 (bit0 bufferable, bit1 cacheable, bit3 write-allocate), aw_burst = 2'b01 (incrementing) and aw_size = log2(DW/8).
- R2: aw_addr is aligned to the bus width, and no burst crosses a 32-byte boundary. Bursts cover the requested range in ascending address order with no gap and no overlap.
- R3: A line-aligned 32-byte stretch inside the range is written as a single burst of 32/(DW/8) beats: 4 beats (aw_len = 3) at 64 bits, 2 beats at 128 bits and 8 beats at 32 bits.
- R4: Every burst length is a power of two. A burst takes the largest power of two that fits both the beats left in the range and the beats left in the current line.
- R5: With ECC enabled, the start is rounded down and the end is rounded up to multiples of 8. A byte lane's strobe is set exactly when its byte address lies in [rounded start, rounded end), so 8-byte groups are always all-on or all-off.
- R6: While a burst is in flight, no new address is issued. Write data for a burst is presented only after its address has been accepted. The next address waits for the previous write response.
- R7: w_data carries the stream words in arrival order. w_last is set on the final beat of each burst only.
- R8: cmd_ready drops in the cycle after a command with nonzero byte count is accepted, and rises only after the last response. A zero-byte command issues no address and leaves cmd_ready high.
- R9: A response with b_resp other than 2'b00 sets err. err remains set while the block is idle and is cleared when the next command is accepted.
- R10: During and directly after reset, cmd_ready = 1, aw_valid = 0, w_valid = 0 and err = 0.
- R11: Once aw_valid is set, it stays set with aw_addr and aw_len unchanged until aw_ready accepts the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command accepted |
| cmd_addr | input | AW | Start byte address |
| cmd_bytes | input | LW | Byte count |
| in_valid | input | 1 | Stream word offered |
| in_ready | output | 1 | Stream word taken |
| in_data | input | DW | Stream word |
| aw_valid | output | 1 | Write address valid |
| aw_ready | input | 1 | Write address accepted |
| aw_addr | output | AW | Burst start address |
| aw_len | output | 8 | Beats minus one |
| aw_size | output | 3 | Beat size code |
| aw_burst | output | 2 | Burst type |
| aw_cache | output | 4 | Cache attributes |
| w_valid | output | 1 | Write data valid |
| w_ready | input | 1 | Write data accepted |
| w_data | output | DW | Write data |
| w_strb | output | DW/8 | Byte strobes |
| w_last | output | 1 | Final beat of burst |
| b_valid | input | 1 | Write response valid |
| b_ready | output | 1 | Response accepted |
| b_resp | input | 2 | Response code |
| err | output | 1 | Sticky error flag |

## Verification
A single clock edge can carry both the error capture from the final write response and the return to the idle state. If err were updated one cycle later than cmd_ready, a controller that watches for ready would read a stale flag. The bench injects an error response on the last burst of some commands and on the first burst of others. At the first sample where cmd_ready is high again, it requires err to be set already. It then requires err to clear once the next clean command is accepted. Random ready and valid stalls on all channels move the point where these events meet.

// File: rtl/line_burst_writer.sv
module line_burst_writer #(
  parameter int DW  = 64,
  parameter int AW  = 32,
  parameter int LW  = 16,
  parameter int ECC = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [AW-1:0] cmd_addr,
  input  logic [LW-1:0] cmd_bytes,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          aw_valid,
  input  logic          aw_ready,
  output logic [AW-1:0] aw_addr,
  output logic [7:0]    aw_len,
  output logic [2:0]    aw_size,
  output logic [1:0]    aw_burst,
  output logic [3:0]    aw_cache,
  output logic          w_valid,
  input  logic          w_ready,
  output logic [DW-1:0] w_data,
  output logic [DW/8-1:0] w_strb,
  output logic          w_last,
  input  logic          b_valid,
  output logic          b_ready,
  input  logic [1:0]    b_resp,
  output logic          err
);
  localparam int NB  = DW / 8;
  localparam int SZ  = $clog2(NB);
  localparam int BPL = 32 / NB;
  localparam int BW  = $clog2(BPL) + 1;

  typedef enum logic [1:0] {IDLE, ADDR, DATA, RESP} st_t;
  st_t st;

  logic [AW-1:0] cur, lim, lo, wa;
  logic [BW-1:0] blen, bcnt;

  function automatic logic [BW-1:0] floor_p2(input logic [BW-1:0] v);
    floor_p2 = '0;
    for (int i = 0; i < BW; i++)
      if (v[i]) floor_p2 = BW'(1) << i;
  endfunction

  wire [AW-1:0] c_end = cmd_addr + AW'(cmd_bytes);
  wire [AW-1:0] lo_n  = (ECC != 0) ? (cmd_addr & ~AW'(7)) : cmd_addr;
  wire [AW-1:0] hi_n  = (ECC != 0) ? ((c_end + AW'(7)) & ~AW'(7)) : c_end;

  wire [AW-1:0] rem_beats = (lim - cur + AW'(NB - 1)) >> SZ;
  wire [BW-1:0] to_line   = BW'(BPL) - BW'(cur[4:SZ]);
  wire [BW-1:0] fit       = (rem_beats < AW'(to_line)) ? BW'(rem_beats) : to_line;
  wire [BW-1:0] blen_c    = floor_p2(fit);

  assign cmd_ready = (st == IDLE);
  assign aw_valid  = (st == ADDR);
  assign aw_addr   = cur;
  assign aw_len    = 8'(blen_c - BW'(1));
  assign aw_size   = 3'(SZ);
  assign aw_burst  = 2'b01;
  assign aw_cache  = 4'b1011;
  assign w_valid   = (st == DATA) && in_valid;
  assign in_ready  = (st == DATA) && w_ready;
  assign w_data    = in_data;
  assign w_last    = (bcnt == blen - BW'(1));
  assign b_ready   = (st == RESP);

  for (genvar i = 0; i < NB; i++) begin : g_lane
    logic [AW-1:0] ba;
    assign ba        = wa + AW'(i);
    assign w_strb[i] = (ba >= lo) && (ba < lim);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= IDLE;
      cur  <= '0;
      lim  <= '0;
      lo   <= '0;
      wa   <= '0;
      blen <= '0;
      bcnt <= '0;
      err  <= 1'b0;
    end else begin
      case (st)
        IDLE: if (cmd_valid) begin
          lo  <= lo_n;
          lim <= hi_n;
          cur <= lo_n & ~AW'(NB - 1);
          err <= 1'b0;
          st  <= (cmd_bytes != '0) ? ADDR : IDLE;
        end
        ADDR: if (aw_ready) begin
          blen <= blen_c;
          bcnt <= '0;
          wa   <= cur;
          st   <= DATA;
        end
        DATA: if (in_valid && w_ready) begin
          bcnt <= bcnt + BW'(1);
          wa   <= wa + AW'(NB);
          if (w_last) st <= RESP;
        end
        RESP: if (b_valid) begin
          if (b_resp != 2'b00) err <= 1'b1;
          cur <= wa;
          st  <= (wa >= lim) ? IDLE : ADDR;
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/line_burst_writer_chk.sv
module line_burst_writer_chk #(
  parameter int DW  = 64,
  parameter int AW  = 32,
  parameter int ECC = 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          aw_valid,
  input logic          aw_ready,
  input logic [AW-1:0] aw_addr,
  input logic [7:0]    aw_len,
  input logic [3:0]    aw_cache,
  input logic          w_valid,
  input logic [DW/8-1:0] w_strb,
  input logic          b_ready
);
  localparam int NB = DW / 8;

  logic grp_ok;
  always_comb begin
    grp_ok = 1'b1;
    for (int g = 0; g < NB / 8; g++)
      if (w_strb[g*8 +: 8] != 8'h00 && w_strb[g*8 +: 8] != 8'hFF) grp_ok = 1'b0;
  end

  a_r1_cache_attr: assert property (@(posedge clk) disable iff (!rst_n)
    aw_valid |-> aw_cache == 4'b1011);

  a_r2_line_fit: assert property (@(posedge clk) disable iff (!rst_n)
    aw_valid |-> (int'(aw_addr[4:0]) + (int'(aw_len) + 1) * NB) <= 32);

  a_r4_len_pow2: assert property (@(posedge clk) disable iff (!rst_n)
    aw_valid |-> $countones(9'(aw_len) + 9'd1) == 1);

  a_r5_group_strb: assert property (@(posedge clk) disable iff (!rst_n)
    (ECC != 0 && w_valid) |-> grp_ok);

  a_r6_one_channel: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({aw_valid, w_valid, b_ready}));

  a_r11_aw_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (aw_valid && !aw_ready) |=> aw_valid && $stable(aw_addr) && $stable(aw_len));
endmodule

bind line_burst_writer line_burst_writer_chk #(.DW(DW), .AW(AW), .ECC(ECC)) u_chk (
  .clk(clk), .rst_n(rst_n), .aw_valid(aw_valid), .aw_ready(aw_ready),
  .aw_addr(aw_addr), .aw_len(aw_len), .aw_cache(aw_cache),
  .w_valid(w_valid), .w_strb(w_strb), .b_ready(b_ready)
);

// File: tb/line_burst_writer_tb.sv
`timescale 1ns/1ps
module line_burst_writer_tb;
  localparam int DW = 64, AW = 32, LW = 16, ECC = 1;
  localparam int NB = DW / 8, BPL = 32 / NB;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_ready;
  logic [AW-1:0] cmd_addr = '0;
  logic [LW-1:0] cmd_bytes = '0;
  logic in_valid = 0, in_ready;
  logic [DW-1:0] in_data = '0;
  logic aw_valid, aw_ready = 0;
  logic [AW-1:0] aw_addr;
  logic [7:0] aw_len;
  logic [2:0] aw_size;
  logic [1:0] aw_burst;
  logic [3:0] aw_cache;
  logic w_valid, w_ready = 0, w_last;
  logic [DW-1:0] w_data;
  logic [NB-1:0] w_strb;
  logic b_valid = 0, b_ready;
  logic [1:0] b_resp = 0;
  logic err;

  always #5 clk = ~clk;

  line_burst_writer #(.DW(DW), .AW(AW), .LW(LW), .ECC(ECC)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_bytes(cmd_bytes), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_addr(aw_addr),
    .aw_len(aw_len), .aw_size(aw_size), .aw_burst(aw_burst), .aw_cache(aw_cache),
    .w_valid(w_valid), .w_ready(w_ready), .w_data(w_data), .w_strb(w_strb),
    .w_last(w_last), .b_valid(b_valid), .b_ready(b_ready), .b_resp(b_resp), .err(err));

  int nchk = 0, nbad = 0;
  longint xa[$];
  int xl[$];
  longint xlo, xhi, mwa;
  int nexp, bdone, pend, beat, curlen, err_mode, awcnt, wcnt;
  bit aw_open, b_fire, wait_b;
  int unsigned dseq = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int unsigned s);
    return {(DW/32){s ^ 32'hA5C30000}};
  endfunction

  function automatic logic [NB-1:0] xstrb(input longint a);
    logic [NB-1:0] r = '0;
    for (int i = 0; i < NB; i++) r[i] = (a + i >= xlo) && (a + i < xhi);
    return r;
  endfunction

  task automatic build(input longint a, input int n);
    longint c;
    xa.delete(); xl.delete();
    xlo = ECC ? (a / 8) * 8 : a;
    xhi = ECC ? ((a + n + 7) / 8) * 8 : a + n;
    if (n == 0) xhi = xlo;
    c = (xlo / NB) * NB;
    while (c < xhi) begin
      int rb, tl, m, p;
      rb = int'((xhi - c + NB - 1) / NB);
      tl = BPL - int'((c % 32) / NB);
      m = rb < tl ? rb : tl;
      p = 1;
      while (p * 2 <= m) p *= 2;
      xa.push_back(c); xl.push_back(p);
      c += p * NB;
    end
    nexp = xa.size();
  endtask

  initial begin : slave
    forever begin
      @(negedge clk);
      if (b_fire) begin b_valid = 0; b_fire = 0; end
      aw_ready = ($urandom_range(0, 3) != 0);
      w_ready  = ($urandom_range(0, 3) != 0);
      in_valid = ($urandom_range(0, 4) != 0);
      in_data  = pat(dseq);
      if (!b_valid && pend > 0 && $urandom_range(0, 1) == 1) begin
        b_valid = 1;
        b_resp = ((err_mode == 1 && bdone == nexp - 1) || (err_mode == 2 && bdone == 0)) ? 2'b10 : 2'b00;
      end
      #1;
      if (aw_valid && aw_ready) begin
        awcnt++;
        chk(!aw_open && !wait_b, "R6 address while burst open", aw_addr, 0);
        chk(xa.size() > 0, "R2 unexpected burst", aw_addr, 0);
        if (xa.size() > 0) begin
          chk(aw_addr == xa[0], "R2 burst address", aw_addr, xa[0]);
          chk(int'(aw_len) + 1 == xl[0], "R4 burst length", aw_len + 1, xl[0]);
          curlen = xl[0];
          void'(xa.pop_front()); void'(xl.pop_front());
        end
        chk(aw_cache == 4'b1011, "R1 cache attr", aw_cache, 4'b1011);
        chk(aw_burst == 2'b01 && aw_size == 3'($clog2(NB)), "R1 burst/size", {aw_burst, aw_size}, {2'b01, 3'($clog2(NB))});
        aw_open = 1; beat = 0; mwa = aw_addr;
      end
      if (w_valid && w_ready) begin
        wcnt++;
        chk(aw_open, "R6 data before address", 0, 1);
        chk(w_data == pat(dseq), "R7 data order", w_data, pat(dseq));
        chk(w_strb == xstrb(mwa), "R5 strobes", w_strb, xstrb(mwa));
        chk(w_last == (beat == curlen - 1), "R7 last flag", w_last, beat == curlen - 1);
        dseq++; beat++; mwa += NB;
        if (w_last) begin aw_open = 0; wait_b = 1; pend++; end
      end
      if (b_valid && b_ready) begin
        pend--; bdone++; b_fire = 1; wait_b = 0;
      end
    end
  end

  task automatic run_cmd(input longint a, input int n, input int em);
    int guard;
    build(a, n);
    err_mode = em; bdone = 0; awcnt = 0; wcnt = 0;
    @(negedge clk); #2;
    cmd_valid = 1; cmd_addr = AW'(a); cmd_bytes = LW'(n);
    @(negedge clk); #2;
    cmd_valid = 0;
    if (n != 0) chk(cmd_ready == 0, "R8 busy after accept", cmd_ready, 0);
    else chk(cmd_ready == 1, "R8 zero-byte stays ready", cmd_ready, 1);
    chk(err == 0, "R9 cleared on accept", err, 0);
    guard = 0;
    while (!cmd_ready && guard < 5000) begin @(negedge clk); #2; guard++; end
    chk(xa.size() == 0, "R2 all bursts issued", xa.size(), 0);
    chk(bdone == nexp, "R8 ready only after last response", bdone, nexp);
    chk(err == (em != 0 && nexp > 0), "R9 error flag at ready", err, em != 0 && nexp > 0);
  endtask

  initial begin : main
    int tot;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    #2;
    chk(cmd_ready == 1, "R10 reset ready", cmd_ready, 1);
    chk(aw_valid == 0, "R10 reset aw_valid", aw_valid, 0);
    chk(w_valid == 0, "R10 reset w_valid", w_valid, 0);
    chk(err == 0, "R10 reset err", err, 0);
    rst_n = 1;

    run_cmd(64'h100, 32, 0);
    chk(awcnt == 1 && wcnt == BPL, "R3 full line one burst", wcnt, BPL);
    run_cmd(64'h1C3, 70, 0);
    run_cmd(64'h205, 1, 0);
    chk(awcnt == 1 && wcnt == 1, "R5 single byte padded group", wcnt, 1);
    run_cmd(64'h300, 0, 0);
    repeat (5) @(negedge clk);
    chk(awcnt == 0, "R8 zero-byte issues nothing", awcnt, 0);
    run_cmd(64'h408, 120, 1);
    repeat (6) @(negedge clk);
    #2;
    chk(err == 1, "R9 sticky while idle", err, 1);
    run_cmd(64'h520, 64, 2);
    run_cmd(64'h600, 96, 0);
    chk(awcnt == 3 && wcnt == 3 * BPL, "R3 three full lines", wcnt, 3 * BPL);

    for (int k = 0; k < 60; k++) begin
      tot = $urandom_range(0, 100);
      run_cmd(longint'($urandom_range(0, 4095)), tot, ($urandom_range(0, 7) == 0) ? 1 : 0);
    end

    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nchk++; nbad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule